// File: doc/BRIEF.md
# Level-sensitive DMA request tracker

This block sits between a bank of peripheral DMA request lines and a handful of DMA channels. It synchronises every request line into the block clock, keeps a mask of the lines that are currently high, and turns a rising edge on a line into a start strobe for every enabled, idle channel that selects that line. A channel whose select is zero is not paced by any line and starts as soon as it is enabled. A synchronised channel that is enabled while its line is already high also starts at once.

A transfer engine outside this block moves the data and reports element and frame boundaries back. At each boundary the tracker raises the enabled boundary flags in the channel status and decides whether a synchronised channel carries on or stops. It carries on while its request line is still high and stops once the line has gone low. A pacing timer is loaded by a line trigger only when it is idle, so a second trigger does not stretch it.

Top module: `dreq_tracker`

## Requirements
- R1: After reset, `line_mask`, `start`, `stop`, `running`, every channel status byte and `pace_active` are all zero.
- R2: Each request line passes through two flip-flops and then the mask register. A level applied to `req_in[i]` appears on `line_mask[i]` after the third rising clock edge.
- R3: When the line picked by a channel's nonzero select rises, an enabled idle channel gets one `start` pulse, goes running and sets status bit 6 (value 0x40). A line held high gives no further pulse. A falling line gives no pulse and leaves a running channel running.
- R4: A select of 0 marks the channel unsynchronised. It starts on the cycle after its enable rises, with status bit 6 clear, and element or frame boundaries never stop it.
- R5: When a channel with a nonzero select is enabled while its line's mask bit is already set, it starts on the next cycle with status bit 6 clear.
- R6: On `elem_done` of a running channel, status bit 2 (0x04) is set if interrupt-enable bit 2 is set. If `ch_fsync` is 0, the select is nonzero and the line is low, the channel gets one `stop` pulse, stops running and clears status bit 6. If the line is high, it keeps running.
- R7: On `frame_done` of a running channel, status bit 3 (0x08) is set if interrupt-enable bit 3 is set. If `ch_fsync` is 1, the select is nonzero and the line is low, the channel stops as in R6. In frame mode, element boundaries never stop the channel.
- R8: A single rising line starts every enabled idle channel that selects it, in the same cycle.
- R9: A low `ch_en` clears running and status bit 6 on the next edge without a `stop` pulse, and it overrides a start due in that same cycle.
- R10: Any line trigger loads the pacing timer with PACE_CYCLES when the timer is idle. `pace_active` is then high for exactly PACE_CYCLES cycles, and a trigger that arrives while the timer is counting does not reload it.
- R11: A rising `ch_en` clears the channel status byte. Status bits other than 2, 3 and 6 are always zero, and disabling a channel keeps bits 2 and 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_in | input | NLINES | Asynchronous peripheral request levels |
| ch_en | input | NCH | Per-channel enable |
| ch_fsync | input | NCH | Per-channel mode: 1 = frame-paced, 0 = element-paced |
| ch_sel | input | NCH*SELW | Per-channel request select, 0 = unsynchronised |
| ch_irq_en | input | NCH*8 | Per-channel interrupt enables (bit 2 element, bit 3 frame) |
| elem_done | input | NCH | Element boundary pulse from the transfer engine |
| frame_done | input | NCH | Frame boundary pulse from the transfer engine |
| start | output | NCH | One-cycle start strobe to the transfer engine |
| stop | output | NCH | One-cycle stop strobe to the transfer engine |
| running | output | NCH | Channel is active |
| status | output | NCH*8 | Per-channel status byte (bit 6 request-started, bit 3 frame, bit 2 element) |
| line_mask | output | NLINES | Lines currently seen as asserted |
| pace_active | output | 1 | Pacing timer is counting |

## Verification
The hardest case to reach is a disable that lands in exactly the cycle where a synchronised rising edge would start the channel. The request path is three registers deep while the enable acts at once, so the bench raises the line and drops the enable two cycles later. This puts both on the same clock edge, and the bench checks that no start pulse appears. Continue-versus-stop at a boundary is reached by holding the line high through one boundary and letting it fall before the next. Every select value from 1 to 31 is swept on one channel.

// File: rtl/dreq_tracker.sv
module dreq_tracker #(
  parameter int NLINES      = 32,
  parameter int NCH         = 4,
  parameter int PACE_CYCLES = 8,
  localparam int SELW = $clog2(NLINES),
  localparam int PW   = $clog2(PACE_CYCLES + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NLINES-1:0]   req_in,
  input  logic [NCH-1:0]      ch_en,
  input  logic [NCH-1:0]      ch_fsync,
  input  logic [NCH*SELW-1:0] ch_sel,
  input  logic [NCH*8-1:0]    ch_irq_en,
  input  logic [NCH-1:0]      elem_done,
  input  logic [NCH-1:0]      frame_done,
  output logic [NCH-1:0]      start,
  output logic [NCH-1:0]      stop,
  output logic [NCH-1:0]      running,
  output logic [NCH*8-1:0]    status,
  output logic [NLINES-1:0]   line_mask,
  output logic                pace_active
);

  logic [NLINES-1:0] sync1, sync2;
  logic [PW-1:0]     pace_cnt;
  logic [NLINES-1:0] rise;

  assign rise        = sync2 & ~line_mask;
  assign pace_active = (pace_cnt != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync1     <= '0;
      sync2     <= '0;
      line_mask <= '0;
      pace_cnt  <= '0;
    end else begin
      sync1     <= req_in;
      sync2     <= sync1;
      line_mask <= sync2;
      if (pace_cnt != '0)
        pace_cnt <= pace_cnt - 1'b1;
      else if (|rise)
        pace_cnt <= PW'(PACE_CYCLES);
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic            en_d;
    logic [7:0]      st;
    logic [SELW-1:0] sel;
    logic [7:0]      ie;
    logic            synced, lvl, hit, en_rise, go, halt;

    assign sel     = ch_sel[c*SELW +: SELW];
    assign ie      = ch_irq_en[c*8 +: 8];
    assign synced  = (sel != '0);
    assign lvl     = sync2[sel];
    assign hit     = synced & rise[sel];
    assign en_rise = ch_en[c] & ~en_d;
    assign go      = ch_en[c] & ~running[c] & (hit | (en_rise & (~synced | lvl)));
    assign halt    = running[c] & synced & ~lvl &
                     ((elem_done[c] & ~ch_fsync[c]) | (frame_done[c] & ch_fsync[c]));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        en_d       <= 1'b0;
        running[c] <= 1'b0;
        start[c]   <= 1'b0;
        stop[c]    <= 1'b0;
        st         <= '0;
      end else begin
        en_d     <= ch_en[c];
        start[c] <= 1'b0;
        stop[c]  <= 1'b0;
        if (!ch_en[c]) begin
          running[c] <= 1'b0;
          st[6]      <= 1'b0;
        end else begin
          if (en_rise) st <= '0;
          if (running[c] && elem_done[c] && ie[2]) st[2] <= 1'b1;
          if (running[c] && frame_done[c] && ie[3]) st[3] <= 1'b1;
          if (hit) st[6] <= 1'b1;
          if (halt) begin
            running[c] <= 1'b0;
            stop[c]    <= 1'b1;
            st[6]      <= 1'b0;
          end else if (go) begin
            running[c] <= 1'b1;
            start[c]   <= 1'b1;
          end
        end
      end
    end

    assign status[c*8 +: 8] = st;
  end

endmodule

module dreq_tracker_chk #(
  parameter int NCH = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NCH-1:0]   ch_en,
  input logic [NCH-1:0]   start,
  input logic [NCH-1:0]   stop,
  input logic [NCH-1:0]   running,
  input logic [NCH*8-1:0] status,
  input logic             pace_active
);

  for (genvar c = 0; c < NCH; c++) begin : g_chk
    p_start_from_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
      start[c] |-> running[c] && !$past(running[c]));

    p_stop_from_run_r6: assert property (@(posedge clk) disable iff (!rst_n)
      stop[c] |-> !running[c] && $past(running[c]) && !status[c*8+6]);

    p_disable_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !ch_en[c] |=> !running[c] && !status[c*8+6] && !start[c] && !stop[c]);

    p_no_start_and_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(start[c] && stop[c]));

    p_status_reserved_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (status[c*8 +: 8] & 8'hB3) == 8'h00);
  end

  p_pace_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pace_active) |=> pace_active);

endmodule

bind dreq_tracker dreq_tracker_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .ch_en(ch_en), .start(start), .stop(stop),
  .running(running), .status(status), .pace_active(pace_active)
);

// File: tb/test_dreq_tracker.sv
module test_dreq_tracker;
  localparam int NL = 32, NC = 4, SW = 5, PACE = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NL-1:0]   req_in = '0;
  logic [NC-1:0]   ch_en = '0, ch_fsync = '0, elem_done = '0, frame_done = '0;
  logic [NC*SW-1:0] ch_sel = '0;
  logic [NC*8-1:0] ch_irq_en = '0;
  logic [NC-1:0]   start, stop, running;
  logic [NC*8-1:0] status;
  logic [NL-1:0]   line_mask;
  logic            pace_active;

  int errors = 0, checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dreq_tracker #(.NLINES(NL), .NCH(NC), .PACE_CYCLES(PACE)) i_dreq_tracker (
    .clk(clk), .rst_n(rst_n), .req_in(req_in), .ch_en(ch_en), .ch_fsync(ch_fsync),
    .ch_sel(ch_sel), .ch_irq_en(ch_irq_en), .elem_done(elem_done),
    .frame_done(frame_done), .start(start), .stop(stop), .running(running),
    .status(status), .line_mask(line_mask), .pace_active(pace_active));

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] st(int c);
    return status[c*8 +: 8];
  endfunction

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    tick(3);
    chk("R1 mask", line_mask, 0);
    chk("R1 running", running, 0);
    chk("R1 strobes", {start, stop}, 0);
    chk("R1 status", status, 0);
    chk("R1 pace", pace_active, 0);
    rst_n = 1'b1;
    tick(1);

    // R2: each line alone, three-edge latency
    for (int i = 0; i < NL; i++) begin
      req_in = 32'(1) << i;
      tick(2);
      chk("R2 early", line_mask, 0);
      tick(1);
      chk("R2 set", line_mask, 32'(1) << i);
      chk("R2 no start when disabled", start, 0);
      req_in = '0;
      tick(3);
      chk("R2 clear", line_mask, 0);
    end
    tick(12);

    // R3 sweep of every nonzero select on channel 0
    for (int s = 1; s < NL; s++) begin
      ch_sel[0 +: SW] = SW'(s);
      ch_en[0] = 1'b1;
      tick(1);
      chk("R3 waits for line", running, 0);
      req_in[s] = 1'b1;
      tick(3);
      chk("R3 start pulse", start, 4'b0001);
      chk("R3 running", running[0], 1);
      chk("R3 status 0x40", st(0), 8'h40);
      tick(1);
      chk("R3 single pulse", start, 0);
      tick(3);
      chk("R3 held level", start, 0);
      req_in[s] = 1'b0;
      tick(3);
      chk("R3 fall no pulse", {start, stop}, 0);
      chk("R3 fall keeps running", running[0], 1);
      ch_en[0] = 1'b0;
      tick(1);
      chk("R9 disable clears", {running[0], st(0)}, 9'h000);
      chk("R9 no stop strobe", stop, 0);
    end
    tick(12);

    // R4 unsynchronised channel 1
    ch_sel[SW +: SW] = '0;
    ch_irq_en[8 +: 8] = 8'h04;
    ch_en[1] = 1'b1;
    tick(1);
    chk("R4 immediate start", start, 4'b0010);
    chk("R4 no 0x40", st(1), 8'h00);
    elem_done[1] = 1'b1;
    tick(1);
    elem_done[1] = 1'b0;
    chk("R4 boundary no stop", {stop[1], running[1]}, 2'b01);
    chk("R6 elem flag on unsync", st(1), 8'h04);
    ch_en[1] = 1'b0;
    tick(2);

    // R5 enable with line already high, then R6 element pacing on channel 2
    ch_sel[2*SW +: SW] = 5'd5;
    ch_irq_en[16 +: 8] = 8'h04;
    ch_fsync[2] = 1'b0;
    req_in[5] = 1'b1;
    tick(4);
    ch_en[2] = 1'b1;
    tick(1);
    chk("R5 immediate start", start, 4'b0100);
    chk("R5 no 0x40", st(2), 8'h00);
    elem_done[2] = 1'b1;
    tick(1);
    elem_done[2] = 1'b0;
    chk("R6 line high continues", {stop[2], running[2]}, 2'b01);
    chk("R6 elem flag", st(2), 8'h04);
    req_in[5] = 1'b0;
    tick(3);
    elem_done[2] = 1'b1;
    tick(1);
    elem_done[2] = 1'b0;
    chk("R6 line low stops", {stop[2], running[2]}, 2'b10);
    chk("R6 status after stop", st(2), 8'h04);
    tick(1);
    chk("R6 stop single pulse", stop, 0);
    req_in[5] = 1'b1;
    tick(3);
    chk("R6 restart on next rise", start, 4'b0100);
    chk("R6 status restart", st(2), 8'h44);
    ch_en[2] = 1'b0;
    req_in[5] = 1'b0;
    tick(4);

    // R7 frame pacing on channel 3
    ch_sel[3*SW +: SW] = 5'd7;
    ch_irq_en[24 +: 8] = 8'h08;
    ch_fsync[3] = 1'b1;
    ch_en[3] = 1'b1;
    tick(1);
    req_in[7] = 1'b1;
    tick(3);
    chk("R7 start", start, 4'b1000);
    req_in[7] = 1'b0;
    tick(3);
    elem_done[3] = 1'b1;
    tick(1);
    elem_done[3] = 1'b0;
    chk("R7 element ignored in frame mode", {stop[3], running[3]}, 2'b01);
    chk("R7 status unchanged", st(3), 8'h40);
    frame_done[3] = 1'b1;
    tick(1);
    frame_done[3] = 1'b0;
    chk("R7 frame stop", {stop[3], running[3]}, 2'b10);
    chk("R7 frame flag", st(3), 8'h08);
    ch_en[3] = 1'b0;
    tick(1);
    chk("R11 disable keeps flags", st(3), 8'h08);
    ch_en[3] = 1'b1;
    tick(1);
    chk("R11 enable clears status", st(3), 8'h00);
    ch_en[3] = 1'b0;
    tick(12);

    // R8 shared line
    ch_sel[0 +: SW] = 5'd9;
    ch_sel[SW +: SW] = 5'd9;
    ch_sel[2*SW +: SW] = 5'd10;
    ch_en[2:0] = 3'b111;
    tick(1);
    req_in[9] = 1'b1;
    tick(3);
    chk("R8 shared start", start, 4'b0011);
    chk("R8 shared running", running, 4'b0011);
    ch_en = '0;
    req_in = '0;
    tick(12);

    // R9 disable in the cycle a start is due
    ch_sel[0 +: SW] = 5'd11;
    ch_en[0] = 1'b1;
    tick(1);
    req_in[11] = 1'b1;
    tick(2);
    ch_en[0] = 1'b0;
    tick(1);
    chk("R9 disable beats start", {start[0], running[0], st(0)}, 10'h000);
    req_in = '0;
    tick(12);

    // R10 pacing timer
    chk("R10 idle", pace_active, 0);
    req_in[12] = 1'b1;
    tick(2);
    chk("R10 not yet", pace_active, 0);
    tick(1);
    chk("R10 loaded", pace_active, 1);
    req_in[13] = 1'b1;
    tick(7);
    chk("R10 still counting", pace_active, 1);
    tick(1);
    chk("R10 no reload", pace_active, 0);
    req_in = '0;
    tick(4);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule